// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block is a small register file that lets a host processor pass commands to an embedded display-control microcontroller. The host reaches it through a plain single-cycle register port with a write strobe, an address and a combinational read path. It exposes a control register, a command register and a set of 32-bit parameter words. The microcontroller side sees the latched command byte and parameter words. It also gets a level interrupt and a pending flag, and it returns a one-cycle done strobe.

A transaction runs as follows. The host polls the doorbell bit until it reads 0, fills the parameter words and then the command byte, and writes 1 to the doorbell. Once the microcontroller has consumed the command, it pulses done, and the doorbell returns to 0. The one bit therefore serves as both the interrupt request and the ready-for-next-command indication. Writes to the payload while the doorbell is set are still accepted, but they raise a sticky overwrite-error flag so that the host can detect the protocol violation.

The microcontroller also owns a firmware-state scratch register that the host can read but not write. The values used are 0 for firmware absent, 1 for loaded but not initialized, and 2 for running. Typical command bytes include 0x20/0x21 (self-refresh enter/leave), 0x23 (self-refresh configure), 0x31 (set wait loop), 0x88/0x89 (initialize, initialize program memory), 0x90/0x91 (lock/unlock PHY) and 0x6A (fractional PWM select). The block latches these codes without interpreting them.

Top module: `mbx_cmd_mailbox`

## Requirements
- R1: A synchronous active-low reset clears the doorbell, the interrupt enable, the overwrite-error flag, the command byte, every parameter word and the state register, so every host read returns 0 and uc_irq and uc_pending are 0.
- R2: A host write to the control register (address 0) with bit 0 set raises the doorbell, which reads back as bit 0. A uc_done pulse clears it in the following cycle. A uc_done pulse while the doorbell is 0 leaves it at 0.
- R3: A host write of 0 to control bit 0 has no effect on a pending doorbell.
- R4: A host write to the command register (address 1) stores only wdata bits 7:0. These bits drive uc_cmd, and a host read of address 1 returns them with bits 31:8 at 0.
- R5: Three independent 32-bit parameter words live at addresses 2, 3 and 4. Word i reads back in full from the host and appears on uc_data bits [32*i+31 : 32*i].
- R6: A write to the command or parameter registers while the doorbell is 1 is still stored, but it sets control bit 2 (overwrite error). That bit stays set until the host writes control with bit 2 set, which clears it. Writing 0 to bit 2 leaves it unchanged, and payload writes made while the doorbell is 0 do not set it.
- R7: Control bit 1 is a read/write interrupt enable. uc_irq is high exactly while the doorbell and that enable are both 1. uc_pending follows the doorbell regardless of the enable.
- R8: uc_state_we loads uc_state_wdata into the state register, which the host reads at address 5 zero-extended to 32 bits. Host writes to address 5 are ignored.
- R9: When a host doorbell write and uc_done fall in the same cycle, the doorbell ends up set.
- R10: Addresses 6 and 7 read as 0, and host writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Host register address (read and write) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| uc_done | input | 1 | Microcontroller done strobe, clears the doorbell |
| uc_state_we | input | 1 | Microcontroller write strobe for the state register |
| uc_state_wdata | input | 8 | Firmware state value to store |
| uc_cmd | output | 8 | Latched command byte |
| uc_data | output | 96 | Parameter words, word i at bits 32*i upward |
| uc_pending | output | 1 | Doorbell level |
| uc_irq | output | 1 | Doorbell gated by the interrupt enable |

## Verification
The assertions assume single-cycle strobes that are sampled only at clock edges. They also assume that host_addr and host_wdata are meaningful only in a cycle where host_we is high, and that uc_done is a pulse rather than a level tied to the doorbell. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It raises uc_done only as a deliberate single pulse, including the cases where the pulse coincides with a host doorbell write or arrives with no doorbell pending. Mid-run reset is applied for two full cycles so that the reset property sees a complete edge.

// File: rtl/mbx_pkg.sv
// Package: shared widths, control-bit positions, command codes and
// firmware state codes for the command mailbox.
package mbx_pkg;

    localparam int HOST_DW = 32;
    localparam int CMD_W   = 8;

    // Control register bit positions (host visible).
    localparam int CTL_BELL = 0;
    localparam int CTL_IEN  = 1;
    localparam int CTL_OVR  = 2;

    // Fixed register addresses; parameter words start at DATA_BASE.
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMD  = 1;
    localparam int DATA_BASE = 2;

    // Command byte values carried through the mailbox (not decoded here).
    typedef enum logic [CMD_W-1:0] {
        CMD_SR_ENTER    = 8'h20,
        CMD_SR_LEAVE    = 8'h21,
        CMD_SR_CONFIG   = 8'h23,
        CMD_WAIT_LOOP   = 8'h31,
        CMD_PWM_FRAC    = 8'h6A,
        CMD_FW_INIT     = 8'h88,
        CMD_PMEM_INIT   = 8'h89,
        CMD_PHY_LOCK    = 8'h90,
        CMD_PHY_UNLOCK  = 8'h91
    } mbx_cmd_e;

    // Firmware state values written by the microcontroller.
    typedef enum logic [1:0] {
        FW_ABSENT  = 2'd0,
        FW_LOADED  = 2'd1,
        FW_RUNNING = 2'd2
    } mbx_fw_e;

endpackage

// File: rtl/mbx_addr_dec.sv
// Module: mbx_addr_dec
// Turns one host write into at most one per-register write enable.
// Assumes host_addr is only meaningful while host_we is high; any
// address not mapped produces no enable.
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int NUM_DATA = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    output logic                ctrl_we,
    output logic                cmd_we,
    output logic [NUM_DATA-1:0] data_we
);

    // Decode the two fixed registers.
    always_comb begin
        ctrl_we = host_we && (host_addr == ADDR_W'(ADDR_CTRL));
        cmd_we  = host_we && (host_addr == ADDR_W'(ADDR_CMD));
    end

    // One enable per parameter word.
    for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_data_dec
        assign data_we[gi] = host_we && (host_addr == ADDR_W'(DATA_BASE + gi));
    end

    // R10: a single host write never reaches two registers.
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, cmd_we, data_we}))
        else $error("a_r10_one_target");

    // R10: no enable without a host write strobe.
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |-> ({ctrl_we, cmd_we, data_we} == '0))
        else $error("a_r10_no_strobe");

endmodule

// File: rtl/mbx_payload_regs.sv
// Module: mbx_payload_regs
// Holds the command byte and the parameter words the host loads before
// ringing the doorbell. Writes are always accepted; protection against
// overwriting a pending command is reported elsewhere, not enforced.
module mbx_payload_regs
    import mbx_pkg::*;
#(
    parameter int NUM_DATA = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_we,
    input  logic [NUM_DATA-1:0]               data_we,
    input  logic [HOST_DW-1:0]                wdata,
    output logic [CMD_W-1:0]                  cmd_q,
    output logic [NUM_DATA-1:0][HOST_DW-1:0]  data_q
);

    // Command byte: only the low byte of the host word is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= wdata[CMD_W-1:0];
    end

    for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_word
        // Parameter word gi: full-width load on its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n)          data_q[gi] <= '0;
            else if (data_we[gi]) data_q[gi] <= wdata;
        end

        // R5: a word changes only when its own enable was seen.
        a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !data_we[gi] |=> $stable(data_q[gi]))
            else $error("a_r5_word_hold");
    end

    // R4: the command byte only moves on a command write.
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q))
        else $error("a_r4_cmd_hold");

endmodule

// File: rtl/mbx_doorbell.sv
// Module: mbx_doorbell
// Doorbell handshake, interrupt enable and sticky overwrite error.
// The host can only set the doorbell; the microcontroller clears it with
// a done pulse. A set and a clear in the same cycle leave it set.
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [HOST_DW-1:0] wdata,
    input  logic               payload_we,
    input  logic               uc_done,
    output logic               bell_q,
    output logic               ien_q,
    output logic               ovr_q,
    output logic               irq
);

    logic bell_set;
    logic ovr_clr;

    // Host-side requests decoded from a control write.
    always_comb begin
        bell_set = ctrl_we && wdata[CTL_BELL];
        ovr_clr  = ctrl_we && wdata[CTL_OVR];
    end

    // Doorbell: host set has priority over the done clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        bell_q <= 1'b0;
        else if (bell_set) bell_q <= 1'b1;
        else if (uc_done)  bell_q <= 1'b0;
    end

    // Interrupt enable: plain read/write control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (ctrl_we) ien_q <= wdata[CTL_IEN];
    end

    // Overwrite error: raised by payload writes under a pending doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovr_q <= 1'b0;
        else if (payload_we && bell_q)  ovr_q <= 1'b1;
        else if (ovr_clr)               ovr_q <= 1'b0;
    end

    // Level interrupt toward the microcontroller.
    assign irq = bell_q && ien_q;

    // R1: reset leaves handshake state idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!bell_q && !ien_q && !ovr_q))
        else $error("a_r1_reset_idle");

    // R2: done without a concurrent set empties the doorbell.
    a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_done && !(ctrl_we && wdata[CTL_BELL])) |=> !bell_q)
        else $error("a_r2_done_clears");

    // R3: a control write with bit 0 low cannot drop a pending doorbell.
    a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_q && !uc_done && ctrl_we && !wdata[CTL_BELL]) |=> bell_q)
        else $error("a_r3_zero_ignored");

    // R6: payload write under a pending doorbell flags an error.
    a_r6_ovr_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (payload_we && bell_q) |=> ovr_q)
        else $error("a_r6_ovr_raise");

    // R6: the error only leaves on an explicit clear.
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(ctrl_we && wdata[CTL_OVR])) |=> ovr_q)
        else $error("a_r6_ovr_sticky");

    // R7: enabling while pending (no done) yields an interrupt next cycle.
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_q && !uc_done && ctrl_we && wdata[CTL_IEN]) |=> irq)
        else $error("a_r7_irq_follows");

    // R9: set and done together end with the doorbell set.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_done && ctrl_we && wdata[CTL_BELL]) |=> bell_q)
        else $error("a_r9_set_wins");

endmodule

// File: rtl/mbx_fw_state.sv
// Module: mbx_fw_state
// Firmware-state scratch register owned by the microcontroller side.
// The host has read access only, via the top-level read mux.
module mbx_fw_state #(
    parameter int STATE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               state_we,
    input  logic [STATE_W-1:0] state_wdata,
    output logic [STATE_W-1:0] state_q
);

    // Load on the microcontroller strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= '0;
        else if (state_we) state_q <= state_wdata;
    end

    // R8: without the microcontroller strobe the value is held.
    a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !state_we |=> $stable(state_q))
        else $error("a_r8_state_hold");

endmodule

// File: rtl/mbx_cmd_mailbox.sv
// Module: mbx_cmd_mailbox
// Top of the host-to-microcontroller command mailbox: address decode,
// payload registers, doorbell handshake, firmware-state scratch and the
// host read mux. Assumes one host access per cycle on a single-cycle port.
module mbx_cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int NUM_DATA = 3,
    parameter int STATE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [HOST_DW-1:0]          host_wdata,
    output logic [HOST_DW-1:0]          host_rdata,
    input  logic                        uc_done,
    input  logic                        uc_state_we,
    input  logic [STATE_W-1:0]          uc_state_wdata,
    output logic [CMD_W-1:0]            uc_cmd,
    output logic [NUM_DATA*HOST_DW-1:0] uc_data,
    output logic                        uc_pending,
    output logic                        uc_irq
);

    localparam int ADDR_STATE = DATA_BASE + NUM_DATA;

    logic                             ctrl_we;
    logic                             cmd_we;
    logic [NUM_DATA-1:0]              data_we;
    logic                             payload_we;
    logic [CMD_W-1:0]                 cmd_q;
    logic [NUM_DATA-1:0][HOST_DW-1:0] data_q;
    logic                             bell_q;
    logic                             ien_q;
    logic                             ovr_q;
    logic                             irq;
    logic [STATE_W-1:0]               state_q;

    mbx_addr_dec #(.ADDR_W(ADDR_W), .NUM_DATA(NUM_DATA)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_addr (host_addr),
        .ctrl_we   (ctrl_we),
        .cmd_we    (cmd_we),
        .data_we   (data_we)
    );

    assign payload_we = cmd_we || (|data_we);

    mbx_payload_regs #(.NUM_DATA(NUM_DATA)) u_payload (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .data_we (data_we),
        .wdata   (host_wdata),
        .cmd_q   (cmd_q),
        .data_q  (data_q)
    );

    mbx_doorbell u_bell (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .wdata      (host_wdata),
        .payload_we (payload_we),
        .uc_done    (uc_done),
        .bell_q     (bell_q),
        .ien_q      (ien_q),
        .ovr_q      (ovr_q),
        .irq        (irq)
    );

    mbx_fw_state #(.STATE_W(STATE_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_we    (uc_state_we),
        .state_wdata (uc_state_wdata),
        .state_q     (state_q)
    );

    // Microcontroller-side outputs.
    assign uc_cmd     = cmd_q;
    assign uc_data    = data_q;
    assign uc_pending = bell_q;
    assign uc_irq     = irq;

    // Host read mux; unmapped addresses return zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(ADDR_CTRL)) begin
            host_rdata[CTL_BELL] = bell_q;
            host_rdata[CTL_IEN]  = ien_q;
            host_rdata[CTL_OVR]  = ovr_q;
        end else if (host_addr == ADDR_W'(ADDR_CMD)) begin
            host_rdata[CMD_W-1:0] = cmd_q;
        end else if (host_addr == ADDR_W'(ADDR_STATE)) begin
            host_rdata[STATE_W-1:0] = state_q;
        end
        for (int i = 0; i < NUM_DATA; i++) begin
            if (host_addr == ADDR_W'(DATA_BASE + i)) host_rdata = data_q[i];
        end
    end

    // R7: an interrupt is never raised without a pending doorbell.
    a_r7_irq_needs_bell: assert property (@(posedge clk) disable iff (!rst_n)
        uc_irq |-> uc_pending)
        else $error("a_r7_irq_needs_bell");

    // R2: a doorbell write with no done lands as pending next cycle.
    a_r2_bell_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_W'(ADDR_CTRL) && host_wdata[CTL_BELL])
        |=> uc_pending)
        else $error("a_r2_bell_rises");

endmodule

// File: tb/test_mbx_cmd_mailbox.sv
// Bench for mbx_cmd_mailbox: a vector table walked by one loop, then
// directed tests for reset and same-cycle corner cases.
module test_mbx_cmd_mailbox;

    localparam logic [2:0] OP_W = 3'd0;  // host write addr, data
    localparam logic [2:0] OP_D = 3'd1;  // uc_done pulse
    localparam logic [2:0] OP_S = 3'd2;  // uc state write data[7:0]
    localparam logic [2:0] OP_R = 3'd3;  // host read addr, expect data
    localparam logic [2:0] OP_I = 3'd4;  // expect {pending, irq}
    localparam logic [2:0] OP_C = 3'd5;  // expect uc_cmd
    localparam logic [2:0] OP_U = 3'd6;  // expect uc_data word addr

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [2:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 42;
    localparam vec_t VEC [NVEC] = '{
        '{OP_W, 4'd5,  3'd2, 32'h11111111},  // R5 fill words
        '{OP_W, 4'd5,  3'd3, 32'h22222222},
        '{OP_W, 4'd5,  3'd4, 32'h33333333},
        '{OP_W, 4'd4,  3'd1, 32'hABCDEF23},  // R4 only low byte kept
        '{OP_R, 4'd4,  3'd1, 32'h00000023},
        '{OP_C, 4'd4,  3'd0, 32'h00000023},
        '{OP_U, 4'd5,  3'd0, 32'h11111111},
        '{OP_U, 4'd5,  3'd1, 32'h22222222},
        '{OP_U, 4'd5,  3'd2, 32'h33333333},
        '{OP_R, 4'd5,  3'd3, 32'h22222222},
        '{OP_R, 4'd6,  3'd0, 32'h00000000},  // R6 idle writes: no error
        '{OP_W, 4'd7,  3'd0, 32'h00000002},  // R7 enable only
        '{OP_I, 4'd7,  3'd0, 32'h00000000},
        '{OP_W, 4'd2,  3'd0, 32'h00000003},  // R2 ring with enable
        '{OP_R, 4'd2,  3'd0, 32'h00000003},
        '{OP_I, 4'd7,  3'd0, 32'h00000003},
        '{OP_W, 4'd3,  3'd0, 32'h00000002},  // R3 zero to bit 0 ignored
        '{OP_R, 4'd3,  3'd0, 32'h00000003},
        '{OP_W, 4'd6,  3'd2, 32'h00000055},  // R6 overwrite while pending
        '{OP_R, 4'd6,  3'd0, 32'h00000007},
        '{OP_R, 4'd6,  3'd2, 32'h00000055},
        '{OP_U, 4'd6,  3'd0, 32'h00000055},
        '{OP_W, 4'd7,  3'd0, 32'h00000000},  // R7 disable irq, pending stays
        '{OP_R, 4'd7,  3'd0, 32'h00000005},
        '{OP_I, 4'd7,  3'd0, 32'h00000002},
        '{OP_D, 4'd2,  3'd0, 32'h00000000},  // R2 done clears doorbell
        '{OP_R, 4'd2,  3'd0, 32'h00000004},
        '{OP_I, 4'd2,  3'd0, 32'h00000000},
        '{OP_W, 4'd6,  3'd1, 32'h00000020},  // R6 idle write keeps sticky
        '{OP_R, 4'd6,  3'd0, 32'h00000004},
        '{OP_C, 4'd4,  3'd0, 32'h00000020},
        '{OP_W, 4'd6,  3'd0, 32'h00000004},  // R6 clear error
        '{OP_R, 4'd6,  3'd0, 32'h00000000},
        '{OP_S, 4'd8,  3'd0, 32'h00000001},  // R8 loaded
        '{OP_R, 4'd8,  3'd5, 32'h00000001},
        '{OP_S, 4'd8,  3'd0, 32'h00000002},  // R8 running
        '{OP_R, 4'd8,  3'd5, 32'h00000002},
        '{OP_W, 4'd8,  3'd5, 32'h000000FF},  // R8 host write ignored
        '{OP_R, 4'd8,  3'd5, 32'h00000002},
        '{OP_W, 4'd10, 3'd6, 32'hFFFFFFFF},  // R10 unmapped write
        '{OP_R, 4'd10, 3'd6, 32'h00000000},
        '{OP_R, 4'd10, 3'd0, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        uc_done = 1'b0;
    logic        uc_state_we = 1'b0;
    logic [7:0]  uc_state_wdata = '0;
    logic [7:0]  uc_cmd;
    logic [95:0] uc_data;
    logic        uc_pending;
    logic        uc_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mbx_cmd_mailbox i_mbx_cmd_mailbox (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_we        (host_we),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .uc_done        (uc_done),
        .uc_state_we    (uc_state_we),
        .uc_state_wdata (uc_state_wdata),
        .uc_cmd         (uc_cmd),
        .uc_data        (uc_data),
        .uc_pending     (uc_pending),
        .uc_irq         (uc_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        uc_done = 1'b1;
        @(negedge clk);
        uc_done = 1'b0;
    endtask

    task automatic state_write(input logic [7:0] d);
        @(negedge clk);
        uc_state_we = 1'b1; uc_state_wdata = d;
        @(negedge clk);
        uc_state_we = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic idle_state_check(input string tag);
        for (int a = 0; a < 8; a++) read_check(tag, 3'(a), 32'h0);
        check(tag, {30'b0, uc_pending, uc_irq}, 32'h0);
        check(tag, {24'b0, uc_cmd}, 32'h0);
        check(tag, uc_data[31:0] | uc_data[63:32] | uc_data[95:64], 32'h0);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_state_check("R1 after reset");

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_W: host_write(VEC[i].addr, VEC[i].data);
                OP_D: done_pulse();
                OP_S: state_write(VEC[i].data[7:0]);
                OP_R: read_check($sformatf("R%0d vec %0d read", VEC[i].req, i),
                                 VEC[i].addr, VEC[i].data);
                OP_I: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vec %0d irq", VEC[i].req, i),
                          {30'b0, uc_pending, uc_irq}, VEC[i].data);
                end
                OP_C: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vec %0d cmd", VEC[i].req, i),
                          {24'b0, uc_cmd}, VEC[i].data);
                end
                OP_U: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vec %0d word", VEC[i].req, i),
                          uc_data[int'(VEC[i].addr)*32 +: 32], VEC[i].data);
                end
                default: ;
            endcase
        end

        // R9: doorbell write and done in the same cycle -> set wins.
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'h1; uc_done = 1'b1;
        @(negedge clk);
        host_we = 1'b0; uc_done = 1'b0;
        read_check("R9 set beats done", 3'd0, 32'h1);

        // R2: done clears it; a stray done with no doorbell keeps it 0.
        done_pulse();
        read_check("R2 cleared", 3'd0, 32'h0);
        done_pulse();
        read_check("R2 stray done", 3'd0, 32'h0);

        // R6: command write in the same cycle as done still flags error.
        host_write(3'd0, 32'h1);
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd1; host_wdata = 32'h91; uc_done = 1'b1;
        @(negedge clk);
        host_we = 1'b0; uc_done = 1'b0;
        read_check("R6 overwrite at done", 3'd0, 32'h4);
        read_check("R4 cmd stored", 3'd1, 32'h91);

        // R1: mid-run reset returns everything to zero.
        host_write(3'd0, 32'h3);
        host_write(3'd4, 32'hDEADBEEF);
        state_write(8'd2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle_state_check("R1 mid-run reset");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule